// File: doc/BRIEF.md
# Early-Evaluation Carry Gate (Phased Logic)

This block models one self-timed gate pair for a phased-logic netlist, sampled on a clock. Each operand travels on two wires: a value rail and a transition rail. The phase of an operand is the XOR of those two rails. The gate holds a phase bit. An operand counts as arrived when its phase equals the gate phase. The pair contains two 4-input lookup cells:

- A **master** cell computes the full-adder carry `maj(A, B, C)`.
- A **trigger** cell looks only at A and B. It reports when the carry is already settled, which is the case when A equals B.

The gate can fire in two ways.

- **Normal firing.** All three operands have arrived and the destination has acknowledged. The output is then driven with the carry, and the gate phase advances.
- **Early firing.** Only A and B have arrived, the trigger is true and the destination has acknowledged. The output is driven at once. The gate then holds without advancing its phase until the late carry-in C arrives. Only then does it complete the computation and accept the next one.

An early firing changes only the order of events. Each computation still produces exactly one output firing and one phase step.

Flow control uses the phase handshake rather than valid/ready signals. `fb_o` tells the sources which phase they may send next. It equals the gate phase and toggles once per completed computation. `fb_i` is the acknowledge coming back from the destination. The gate fires only when `fb_i` equals the gate phase, so a destination that has not consumed the last output holds the gate back.

After reset, the sources must present phase 1, meaning no token. The destination must hold `fb_i` at 0. A counter reports how many firings were early.

Top module: `ee_carry_gate`

## Requirements
- R1: After reset, `y_val`=0 and `y_trn`=1 (output phase 1, no token), `fb_o`=0 and `early_cnt`=0.
- R2: When A, B and C all have phase equal to `fb_o` and `fb_i` equals `fb_o`, the output fires at the next clock edge, and `fb_o` toggles at that same edge. This holds even if A equals B. Such a firing does not increment `early_cnt`.
- R3: When A and B have arrived, C has not, `a_val` equals `b_val` and `fb_i` equals `fb_o`, the output fires at the next edge with `y_val` equal to `a_val`. At that edge `early_cnt` increments by one and `fb_o` does not change.
- R4: When A and B have arrived, C has not and `a_val` differs from `b_val`, the output phase and value do not change.
- R5: After an early firing, the output does not fire again and `fb_o` holds. When C then arrives with the current phase, `fb_o` toggles at the next edge, with no further output change.
- R6: The output never fires while `fb_i` differs from `fb_o`.
- R7: Every firing sets the output phase (`y_val` XOR `y_trn`) to the gate phase, and `y_val` equal to `maj(a_val, b_val, c_val)`.
- R8: `early_cnt` changes only on early firings and steps by exactly one each time. Over a stream of operands with a late carry-in, it rises once for every operand with A equal to B.
- R9: The phase of an operand is its value rail XOR its transition rail. An operand whose phase differs from `fb_o` is treated as not arrived.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_val | input | 1 | Operand A value rail |
| a_trn | input | 1 | Operand A transition rail |
| b_val | input | 1 | Operand B value rail |
| b_trn | input | 1 | Operand B transition rail |
| c_val | input | 1 | Carry-in value rail |
| c_trn | input | 1 | Carry-in transition rail |
| fb_i | input | 1 | Acknowledge from destination; gate may fire when equal to gate phase |
| y_val | output | 1 | Carry output value rail |
| y_trn | output | 1 | Carry output transition rail |
| fb_o | output | 1 | Gate phase; tells sources which phase to send next |
| early_cnt | output | CNT_W | Number of early firings |

## Verification
All eight operand combinations are applied with the carry-in sent late. In this pattern the A=B cases must fire before C arrives, and the A≠B cases must wait for C. The same operands are also sent all together, and again with the carry-in first. These two patterns separate an early firing from a normal firing on the counter and on `fb_o`.

A withheld acknowledge shows that the destination can hold the gate back. A long hold after an early firing shows there is no second firing. A random stream compares the early count against the number of A=B operands.

// File: rtl/ee_pkg.sv
package ee_pkg;
  localparam int NOPS = 3;

  typedef enum logic [1:0] {
    FK_NONE  = 2'd0,
    FK_FULL  = 2'd1,
    FK_EARLY = 2'd2,
    FK_LATE  = 2'd3
  } fire_kind_e;

  function automatic logic ledr_phase(input logic v, input logic t);
    return v ^ t;
  endfunction
endpackage

// File: rtl/ledr_rx.sv
module ledr_rx #(
  parameter int N = 3
) (
  input  logic [N-1:0] val,
  input  logic [N-1:0] trn,
  input  logic         gate_ph,
  output logic [N-1:0] arrived
);
  for (genvar i = 0; i < N; i++) begin : g_op
    assign arrived[i] = (ee_pkg::ledr_phase(val[i], trn[i]) == gate_ph);
  end
endmodule

// File: rtl/lut4_cell.sv
module lut4_cell #(
  parameter logic [15:0] INIT = 16'h0000
) (
  input  logic [3:0] sel,
  output logic       y
);
  assign y = INIT[sel];
endmodule

// File: rtl/ee_ctrl.sv
module ee_ctrl
  import ee_pkg::*;
#(
  parameter int          N      = 3,
  parameter logic [N-1:0] SUBSET = 3'b011
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] arrived,
  input  logic         trig,
  input  logic         fb_ok,
  output fire_kind_e   kind,
  output logic         gate_ph
);
  logic waiting;
  logic all_in, sub_in;

  assign all_in = &arrived;
  assign sub_in = &(arrived | ~SUBSET);

  always_comb begin
    kind = FK_NONE;
    if (waiting) begin
      if (all_in) kind = FK_LATE;
    end else if (all_in && fb_ok) begin
      kind = FK_FULL;
    end else if (sub_in && trig && fb_ok) begin
      kind = FK_EARLY;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_ph <= 1'b0;
      waiting <= 1'b0;
    end else begin
      case (kind)
        FK_FULL:  gate_ph <= ~gate_ph;
        FK_EARLY: waiting <= 1'b1;
        FK_LATE: begin
          waiting <= 1'b0;
          gate_ph <= ~gate_ph;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ee_carry_gate.sv
module ee_carry_gate
  import ee_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_val,
  input  logic             a_trn,
  input  logic             b_val,
  input  logic             b_trn,
  input  logic             c_val,
  input  logic             c_trn,
  input  logic             fb_i,
  output logic             y_val,
  output logic             y_trn,
  output logic             fb_o,
  output logic [CNT_W-1:0] early_cnt
);
  localparam logic [15:0] MASTER_INIT = 16'hE8E8;
  localparam logic [15:0] TRIG_INIT   = 16'h9999;

  logic [NOPS-1:0] vals, trns, arr;
  logic            gph, m_y, t_y;
  fire_kind_e      kind;

  assign vals = {c_val, b_val, a_val};
  assign trns = {c_trn, b_trn, a_trn};

  ledr_rx #(.N(NOPS)) rx_i (
    .val(vals), .trn(trns), .gate_ph(gph), .arrived(arr)
  );

  lut4_cell #(.INIT(MASTER_INIT)) master_i (.sel({1'b0, vals}), .y(m_y));
  lut4_cell #(.INIT(TRIG_INIT))   trig_i   (.sel({1'b0, vals}), .y(t_y));

  ee_ctrl #(.N(NOPS), .SUBSET(3'b011)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .arrived(arr), .trig(t_y),
    .fb_ok(fb_i == gph), .kind(kind), .gate_ph(gph)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y_val     <= 1'b0;
      y_trn     <= 1'b1;
      early_cnt <= '0;
    end else begin
      if (kind == FK_FULL || kind == FK_EARLY) begin
        y_val <= m_y;
        y_trn <= m_y ^ gph;
      end
      if (kind == FK_EARLY) early_cnt <= early_cnt + 1'b1;
    end
  end

  assign fb_o = gph;
endmodule

// File: rtl/ee_carry_gate_chk.sv
module ee_carry_gate_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             a_val,
  input logic             a_trn,
  input logic             b_val,
  input logic             b_trn,
  input logic             c_val,
  input logic             c_trn,
  input logic             fb_i,
  input logic             y_val,
  input logic             y_trn,
  input logic             fb_o,
  input logic [CNT_W-1:0] early_cnt
);
  logic y_ph, maj;
  assign y_ph = y_val ^ y_trn;
  assign maj  = (a_val & b_val) | (c_val & (a_val | b_val));

  AST_OUT_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(y_ph) |-> $past(fb_i) == $past(fb_o)); // R6
  AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(y_ph) |-> $past(y_ph) != $past(fb_o)); // R5
  AST_CARRY_OK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(y_ph) |-> y_val == $past(maj) && y_ph == $past(fb_o)); // R7
  AST_EARLY_EQ: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(early_cnt) |-> $past(a_val) == $past(b_val) && $stable(fb_o)); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(early_cnt) |-> early_cnt == CNT_W'($past(early_cnt) + 1'b1)); // R8
  AST_PHASE_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fb_o) |-> $past((a_val ^ a_trn) == fb_o && (b_val ^ b_trn) == fb_o
                              && (c_val ^ c_trn) == fb_o)); // R9
endmodule

bind ee_carry_gate ee_carry_gate_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .a_val(a_val), .a_trn(a_trn), .b_val(b_val),
  .b_trn(b_trn), .c_val(c_val), .c_trn(c_trn), .fb_i(fb_i), .y_val(y_val),
  .y_trn(y_trn), .fb_o(fb_o), .early_cnt(early_cnt)
);

// File: tb/ee_carry_gate_tb_top.sv
`timescale 1ns/1ps
module ee_carry_gate_tb_top;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_val = 0, a_trn = 1, b_val = 0, b_trn = 1, c_val = 0, c_trn = 1;
  logic fb_i = 0;
  logic y_val, y_trn, fb_o;
  logic [CNT_W-1:0] early_cnt;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic ph = 0;

  always #2.5 clk = ~clk;

  ee_carry_gate #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .a_val(a_val), .a_trn(a_trn), .b_val(b_val),
    .b_trn(b_trn), .c_val(c_val), .c_trn(c_trn), .fb_i(fb_i), .y_val(y_val),
    .y_trn(y_trn), .fb_o(fb_o), .early_cnt(early_cnt)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic carry(input logic a, input logic b, input logic c);
    return (a & b) | (c & (a | b));
  endfunction

  task automatic send_ab(input logic a, input logic b, input logic p);
    a_val = a; a_trn = a ^ p; b_val = b; b_trn = b ^ p;
  endtask

  task automatic send_c(input logic c, input logic p);
    c_val = c; c_trn = c ^ p;
  endtask

  task automatic t_reset();
    step(1);
    chk(y_val == 0 && y_trn == 1, "R1 output", {y_val, y_trn}, 1);
    chk(fb_o == 0, "R1 fb_o", fb_o, 0);
    chk(early_cnt == 0, "R1 count", early_cnt, 0);
  endtask

  // carry-in late; hold cycles after the A/B step; consume selects ack
  task automatic t_late_c(input logic a, input logic b, input logic c,
                          input int hold, input bit consume);
    int c0 = early_cnt;
    bit ee = (a == b);
    send_ab(a, b, ph);
    step(2 + hold);
    if (ee) begin
      chk((y_val ^ y_trn) == ph && y_val == a, "R3 early fire", {y_val, y_trn}, a);
      chk(early_cnt == c0 + 1, "R3 count", early_cnt, c0 + 1);
      chk(fb_o == ph, "R5 phase held", fb_o, ph);
    end else begin
      chk((y_val ^ y_trn) != ph, "R4 waits for carry-in", y_val ^ y_trn, !ph);
      chk(early_cnt == c0, "R4 count", early_cnt, c0);
    end
    send_c(c, ph);
    step(2);
    chk((y_val ^ y_trn) == ph, "R7 phase", y_val ^ y_trn, ph);
    chk(y_val == carry(a, b, c), "R7 value", y_val, carry(a, b, c));
    chk(fb_o == !ph, "R5 completion", fb_o, !ph);
    chk(early_cnt == c0 + (ee ? 1 : 0), "R8 count", early_cnt, c0 + (ee ? 1 : 0));
    ph = !ph;
    if (consume) fb_i = ph;
  endtask

  task automatic t_all_exhaustive();
    for (int k = 0; k < 8; k++) t_late_c(k[0], k[1], k[2], 0, 1);
  endtask

  task automatic t_hold_after_early();
    t_late_c(1, 1, 0, 6, 1); // R5 long hold, no refire
  endtask

  task automatic t_together();
    int c0 = early_cnt;
    send_ab(1, 1, ph); send_c(0, ph);
    step(2);
    chk(y_val == 1 && (y_val ^ y_trn) == ph, "R2 full fire", y_val, 1);
    chk(early_cnt == c0, "R2 not early", early_cnt, c0);
    chk(fb_o == !ph, "R2 fb_o toggles", fb_o, !ph);
    ph = !ph; fb_i = ph;
  endtask

  task automatic t_c_first();
    int c0 = early_cnt;
    send_c(1, ph);
    step(2);
    chk((y_val ^ y_trn) != ph, "R9 C alone no fire", y_val ^ y_trn, !ph);
    send_ab(0, 0, ph);
    step(2);
    chk(y_val == 0 && (y_val ^ y_trn) == ph, "R2 C first", y_val, 0);
    chk(early_cnt == c0, "R2 C first count", early_cnt, c0);
    ph = !ph; fb_i = ph;
  endtask

  task automatic t_ack_block();
    logic pre;
    t_late_c(0, 1, 1, 0, 0); // destination does not consume
    pre = y_val ^ y_trn;
    send_ab(0, 0, ph); send_c(0, ph);
    step(4);
    chk((y_val ^ y_trn) == pre, "R6 blocked", y_val ^ y_trn, pre);
    chk(fb_o == ph, "R6 phase held", fb_o, ph);
    fb_i = ph;
    step(2);
    chk((y_val ^ y_trn) == ph && y_val == 0, "R6 released", y_val ^ y_trn, ph);
    ph = !ph; fb_i = ph;
  endtask

  task automatic t_random();
    int c0 = early_cnt;
    int exp_ee = 0;
    for (int k = 0; k < 60; k++) begin
      logic a = 1'($urandom), b = 1'($urandom), c = 1'($urandom);
      if (a == b) exp_ee++;
      t_late_c(a, b, c, 0, 1);
    end
    chk(early_cnt == c0 + exp_ee, "R8 random early total", early_cnt, c0 + exp_ee);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1;
    t_reset();
    t_all_exhaustive();
    t_hold_after_early();
    t_together();
    t_c_first();
    t_ack_block();
    t_random();
    step(2);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule